// File: doc/BRIEF.md
# Command-Word Transmit Packet Assembler

A host writes 32-bit words into one transmit data port, and this block rebuilds outgoing frames from them. Every buffer begins with two command words. The first command word sets the byte count, a leading byte offset, the segment position flags, an end-alignment selector and a completion-interrupt request. The second command word carries a 16-bit packet tag. After the two command words come the data words. The block discards the offset bytes, unpacks the payload bytes least significant byte first and presents them one at a time on a valid/ready byte stream. It marks the first and the last byte of each frame. It then consumes the alignment pad words, which produce no data.

When a buffer flagged as the last segment completes, the block pushes the frame's tag into a status FIFO that the host drains. The block also reports the free space of its data storage in words, flags writes that would overflow it, and pulses an interrupt when a buffer that asked for one completes. A soft clear drops any partly assembled buffer. A separate clear empties the status FIFO.

Top module: `tx_cmd_assembler`

## Requirements
- R1: After reset the parser waits for a first command word, no byte is offered, the status FIFO is empty and not full, free space equals FIFO_WORDS, and writes are accepted.
- R2: First command word, after masking with 0x831F37FF: bits 10:0 byte count, bits 20:16 leading offset, bit 13 first segment, bit 12 last segment, bits 25:24 alignment selector, bit 31 completion interrupt. The next word is the second command word. Bits 31:16 of that word become the tag only when the first-segment bit is set; otherwise the word is discarded. Byte count, offset and pad are loaded for every buffer.
- R3: While the remaining offset is 4 or more, each data word is discarded whole and the offset drops by 4. A remaining offset of 1 to 3 removes that many low-order bytes from the next data word.
- R4: Bytes leave a data word least significant first. A word yields no more bytes than the buffer still owes.
- R5: Pad words follow the payload. With n = (count + offset + 3) / 4, selector 1 pads n up to a multiple of 4, selector 2 up to a multiple of 8, and other values add none. Pad words produce no bytes.
- R6: A buffer completes once both its remaining count and its remaining pad are zero; a buffer whose count and pad are zero completes on its second command word. The first byte after a first-segment buffer carries the start marker. When the last-segment bit is set, the final payload byte carries the end marker, the tag is pushed into the status FIFO and the used-word count returns to zero.
- R7: A completing buffer with bit 31 set gives a one-cycle interrupt pulse in the cycle after the completing write.
- R8: The status FIFO holds STAT_DEPTH (512) tags in arrival order. The full flag is high while it holds STAT_DEPTH entries. A push while it is full is lost, and a pop while it is empty has no effect. An empty FIFO shows tag 0.
- R9: First command words, tag-carrying second command words and byte-carrying data words each add one to the used count, and free space is FIFO_WORDS minus that count. A write accepted while the count equals FIFO_WORDS is dropped and pulses the overflow output for one cycle.
- R10: A soft clear returns the parser to waiting for a first command word, zeroes the used count, drops pending bytes and discards a write in the same cycle.
- R11: A status clear empties the status FIFO in one cycle, taking priority over a push or pop in that cycle.
- R12: No write is accepted while bytes from an earlier word are still pending. A byte offered and not taken stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_clear | input | 1 | Drops the buffer being assembled and zeroes the used count |
| stat_clear | input | 1 | Empties the status FIFO |
| wr_valid | input | 1 | Host word present |
| wr_data | input | 32 | Host word (command or data) |
| wr_ready | output | 1 | Block can take a word |
| tx_valid | output | 1 | Byte offered |
| tx_ready | input | 1 | Byte taken |
| tx_data | output | 8 | Frame byte |
| tx_first | output | 1 | Byte opens a frame |
| tx_last | output | 1 | Byte closes a frame |
| st_pop | input | 1 | Removes the head status entry |
| st_valid | output | 1 | Status FIFO not empty |
| st_tag | output | 16 | Tag at the head of the status FIFO |
| st_full | output | 1 | Status FIFO full |
| free_words | output | $clog2(FIFO_WORDS+1) | Free data storage in words |
| done_irq | output | 1 | Completion interrupt pulse |
| drop_evt | output | 1 | Overflow drop pulse |

## Verification
The hardest states to reach are the two storage limits. Filling the status FIFO takes 512 complete frames. Bringing the used count up to its limit takes more than a thousand words spread across several segments, none of them marked last. The bench reaches the first limit with zero-length first-and-last buffers, which complete on their second command word. It reaches the second with full-size buffers that are not last segments, writing until its own model reports no free words, and then sends one more word. Random stalls of the byte output during the framing tests also check that writes are held back while bytes are still pending.

// File: rtl/txa_pkg.sv
package txa_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_CMDB = 2'd1,
    PS_DATA = 2'd2
  } pstate_e;

  // Fields of the first command word that the parser keeps
  typedef struct packed {
    logic        ioc;
    logic [1:0]  align;
    logic [4:0]  lead;
    logic        first;
    logic        last;
    logic [10:0] nbytes;
  } cmda_t;

  localparam logic [31:0] CMDA_KEEP = 32'h831F_37FF;

  function automatic cmda_t f_cmda(input logic [31:0] w);
    logic [31:0] m;
    cmda_t c;
    m        = w & CMDA_KEEP;
    c.ioc    = m[31];
    c.align  = m[25:24];
    c.lead   = m[20:16];
    c.first  = m[13];
    c.last   = m[12];
    c.nbytes = m[10:0];
    return c;
  endfunction

  // Pad words needed after the payload, counted in words
  function automatic logic [2:0] f_pad_words(input logic [10:0] sz,
                                             input logic [4:0]  off,
                                             input logic [1:0]  sel);
    logic [11:0] tot;
    logic [9:0]  words;
    tot   = {1'b0, sz} + {7'd0, off} + 12'd3;
    words = tot[11:2];
    case (sel)
      2'd1:    return {1'b0, (~words[1:0]) + 2'd1};
      2'd2:    return (~words[2:0]) + 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  // Bytes one data word yields, given the intra-word offset and bytes owed
  function automatic logic [2:0] f_take(input logic [1:0]  off,
                                        input logic [10:0] owed);
    logic [2:0] avail;
    avail = 3'd4 - {1'b0, off};
    if (owed < {8'd0, avail}) return owed[2:0];
    return avail;
  endfunction

endpackage

// File: rtl/txa_serializer.sv
module txa_serializer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        ld,
  input  logic [31:0] ld_bytes,
  input  logic [2:0]  ld_cnt,
  input  logic        ld_first,
  input  logic        ld_last,
  output logic        busy,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_first,
  output logic        tx_last
);

  logic [31:0] sh;
  logic [2:0]  cnt;
  logic        first_q;
  logic        last_q;
  logic        take_evt;

  assign take_evt = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      cnt     <= '0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (flush) begin
      cnt     <= '0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (ld) begin
      sh      <= ld_bytes;
      cnt     <= ld_cnt;
      first_q <= ld_first;
      last_q  <= ld_last;
    end else if (take_evt) begin
      sh      <= {8'd0, sh[31:8]};
      cnt     <= cnt - 3'd1;
      first_q <= 1'b0;
    end
  end

  assign busy     = (cnt != 3'd0);
  assign tx_valid = busy;
  assign tx_data  = sh[7:0];
  assign tx_first = first_q;
  assign tx_last  = last_q && (cnt == 3'd1);

  // R12: an offered byte that is not taken stays put
  p_hold_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !flush |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  // R12: a new word never lands on pending bytes
  p_load_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> cnt == 3'd0);

endmodule

// File: rtl/txa_stat_fifo.sv
module txa_stat_fifo #(
  parameter int DEPTH = 512,
  parameter int TW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [TW-1:0] push_tag,
  input  logic          pop,
  output logic          valid,
  output logic [TW-1:0] head,
  output logic          full
);

  logic [TW-1:0] mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;
  logic [CW-1:0] cnt;
  logic          push_ok;
  logic          pop_ok;

  function automatic logic [AW-1:0] f_wrap(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + AW'(1);
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign valid   = (cnt != '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && valid && !clr;
  assign head    = valid ? mem[rp] : '0;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= f_wrap(wp);
      if (pop_ok)  rp <= f_wrap(rp);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R8: a full FIFO stays full until something leaves it
  p_full_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop && !clr |=> full);

  // R11: a clear leaves the FIFO empty
  p_clr_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !valid);

endmodule

// File: rtl/txa_parser.sv
module txa_parser
  import txa_pkg::*;
#(
  parameter int FIFO_WORDS = 1152,
  localparam int USED_W    = $clog2(FIFO_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clear,
  input  logic              wr_fire,
  input  logic [31:0]       wr_data,
  output logic              ld,
  output logic [31:0]       ld_bytes,
  output logic [2:0]        ld_cnt,
  output logic              ld_first,
  output logic              ld_last,
  output logic              stat_push,
  output logic [15:0]       stat_tag,
  output logic [USED_W-1:0] used_words,
  output logic              done_irq,
  output logic              drop_evt
);

  pstate_e           st;
  cmda_t             ca;
  logic [15:0]       tag_q;
  logic [10:0]       rem_sz;
  logic [4:0]        rem_off;
  logic [2:0]        rem_pad;
  logic [USED_W-1:0] used;
  logic              pend_first;
  logic              done_q;
  logic              drop_q;

  // Named internal events
  logic       at_limit;
  logic       acc;
  logic       drop_now;
  logic [2:0] new_pad;
  logic       skip_w;
  logic       pad_w;
  logic [2:0] take;
  logic       fin_bytes;
  logic       cmpl;
  logic       count_w;

  always_comb begin
    at_limit  = (used == USED_W'(FIFO_WORDS));
    acc       = wr_fire && !at_limit;
    drop_now  = wr_fire && at_limit;
    new_pad   = f_pad_words(ca.nbytes, ca.lead, ca.align);
    skip_w    = (rem_off >= 5'd4);
    pad_w     = !skip_w && (rem_sz == 11'd0);
    take      = f_take(rem_off[1:0], rem_sz);
    fin_bytes = ({8'd0, take} == rem_sz);
    ld        = acc && (st == PS_DATA) && !skip_w && !pad_w;
    case (st)
      PS_CMDB: cmpl = acc && (ca.nbytes == 11'd0) && (new_pad == 3'd0);
      PS_DATA: cmpl = acc && !skip_w &&
                      (pad_w ? (rem_pad == 3'd1) : (fin_bytes && rem_pad == 3'd0));
      default: cmpl = 1'b0;
    endcase
    count_w   = acc && ((st == PS_IDLE) || (st == PS_CMDB && ca.first) || ld);
    ld_bytes  = wr_data >> {rem_off[1:0], 3'b000};
    ld_cnt    = take;
    ld_first  = pend_first;
    ld_last   = ca.last && fin_bytes;
    stat_push = cmpl && ca.last;
    stat_tag  = (st == PS_CMDB && ca.first) ? wr_data[31:16] : tag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= PS_IDLE;
      ca         <= '1;
      tag_q      <= '0;
      rem_sz     <= '0;
      rem_off    <= '0;
      rem_pad    <= '0;
      used       <= '0;
      pend_first <= 1'b0;
      done_q     <= 1'b0;
      drop_q     <= 1'b0;
    end else if (soft_clear) begin
      st         <= PS_IDLE;
      ca         <= '1;
      used       <= '0;
      pend_first <= 1'b0;
      done_q     <= 1'b0;
      drop_q     <= 1'b0;
    end else begin
      done_q <= cmpl && ca.ioc;
      drop_q <= drop_now;
      if (acc) begin
        case (st)
          PS_IDLE: begin
            ca <= f_cmda(wr_data);
            st <= PS_CMDB;
          end
          PS_CMDB: begin
            rem_sz  <= ca.nbytes;
            rem_off <= ca.lead;
            rem_pad <= new_pad;
            if (ca.first) begin
              tag_q      <= wr_data[31:16];
              pend_first <= 1'b1;
            end
            st <= cmpl ? PS_IDLE : PS_DATA;
          end
          PS_DATA: begin
            if (skip_w) begin
              rem_off <= rem_off - 5'd4;
            end else if (pad_w) begin
              if (rem_pad != 3'd0) rem_pad <= rem_pad - 3'd1;
            end else begin
              rem_sz     <= rem_sz - {8'd0, take};
              rem_off    <= '0;
              pend_first <= 1'b0;
            end
            if (cmpl) st <= PS_IDLE;
          end
          default: st <= PS_IDLE;
        endcase
      end
      if (cmpl && ca.last) begin
        used       <= '0;
        pend_first <= 1'b0;
      end else if (count_w) begin
        used <= used + USED_W'(1);
      end
    end
  end

  assign used_words = used;
  assign done_irq   = done_q;
  assign drop_evt   = drop_q;

  // R9: the used count never exceeds the storage size
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    used <= USED_W'(FIFO_WORDS));

  // R9: a dropped write leaves the count alone
  p_drop_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_now |=> $stable(used));

  // R10: soft clear parks the parser with nothing counted
  p_clear_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clear |=> (st == PS_IDLE) && (used == '0));

  // R7: the completion interrupt is a single-cycle pulse
  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

endmodule

// File: rtl/tx_cmd_assembler.sv
module tx_cmd_assembler #(
  parameter int FIFO_WORDS = 1152,
  parameter int STAT_DEPTH = 512,
  localparam int USED_W    = $clog2(FIFO_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clear,
  input  logic              stat_clear,
  input  logic              wr_valid,
  input  logic [31:0]       wr_data,
  output logic              wr_ready,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_first,
  output logic              tx_last,
  input  logic              st_pop,
  output logic              st_valid,
  output logic [15:0]       st_tag,
  output logic              st_full,
  output logic [USED_W-1:0] free_words,
  output logic              done_irq,
  output logic              drop_evt
);

  logic              busy;
  logic              wr_fire;
  logic              ld;
  logic [31:0]       ld_bytes;
  logic [2:0]        ld_cnt;
  logic              ld_first;
  logic              ld_last;
  logic              stat_push;
  logic [15:0]       stat_tag;
  logic [USED_W-1:0] used_words;

  assign wr_ready   = !busy;
  assign wr_fire    = wr_valid && wr_ready && !soft_clear;
  assign free_words = USED_W'(FIFO_WORDS) - used_words;

  txa_parser #(.FIFO_WORDS(FIFO_WORDS)) u_parser (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_clear (soft_clear),
    .wr_fire    (wr_fire),
    .wr_data    (wr_data),
    .ld         (ld),
    .ld_bytes   (ld_bytes),
    .ld_cnt     (ld_cnt),
    .ld_first   (ld_first),
    .ld_last    (ld_last),
    .stat_push  (stat_push),
    .stat_tag   (stat_tag),
    .used_words (used_words),
    .done_irq   (done_irq),
    .drop_evt   (drop_evt)
  );

  txa_serializer u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (soft_clear),
    .ld       (ld),
    .ld_bytes (ld_bytes),
    .ld_cnt   (ld_cnt),
    .ld_first (ld_first),
    .ld_last  (ld_last),
    .busy     (busy),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_first (tx_first),
    .tx_last  (tx_last)
  );

  txa_stat_fifo #(.DEPTH(STAT_DEPTH), .TW(16)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (stat_clear),
    .push     (stat_push),
    .push_tag (stat_tag),
    .pop      (st_pop),
    .valid    (st_valid),
    .head     (st_tag),
    .full     (st_full)
  );

endmodule

// File: tb/tx_cmd_assembler_bench.sv
module tx_cmd_assembler_bench;
  localparam int CLK_NS = 10;
  localparam int FW     = 1152;
  localparam int SD     = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_clear = 1'b0;
  logic        stat_clear = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic        tx_first;
  logic        tx_last;
  logic        st_pop = 1'b0;
  logic        st_valid;
  logic [15:0] st_tag;
  logic        st_full;
  logic [10:0] free_words;
  logic        done_irq;
  logic        drop_evt;

  tx_cmd_assembler u_tx_cmd_assembler (
    .clk(clk), .rst_n(rst_n), .soft_clear(soft_clear), .stat_clear(stat_clear),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_first(tx_first), .tx_last(tx_last), .st_pop(st_pop),
    .st_valid(st_valid), .st_tag(st_tag), .st_full(st_full),
    .free_words(free_words), .done_irq(done_irq), .drop_evt(drop_evt)
  );

  always #(CLK_NS/2) clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  int n_done  = 0;
  int n_drop  = 0;
  bit stall_en = 1'b0;

  // Reference model state
  int          m_state;
  logic [31:0] m_a;
  int          m_tag, m_size, m_off, m_pad, m_used;
  bit          m_pf;
  bit          exp_done, exp_drop;
  int          qb[$];
  int          qs[$];

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_write(input logic [31:0] w, output bit push, output int ptag);
    int sz, of, sel, n;
    bit fin;
    push = 0; ptag = 0; fin = 0;
    if (m_used == FW) begin
      exp_drop = 1;
      return;
    end
    case (m_state)
      0: begin
        m_a = w & 32'h831F37FF;
        m_used++;
        m_state = 1;
      end
      1: begin
        sz  = int'(m_a[10:0]);
        of  = int'(m_a[20:16]);
        sel = int'(m_a[25:24]);
        n   = (sz + of + 3) / 4;
        m_pad  = (sel == 1) ? (4 - n % 4) % 4 : (sel == 2) ? (8 - n % 8) % 8 : 0;
        m_size = sz;
        m_off  = of;
        if (m_a[13]) begin
          m_tag = int'(w[31:16]);
          m_used++;
          m_pf = 1;
        end
        if (sz == 0 && m_pad == 0) fin = 1; else m_state = 2;
      end
      default: begin
        if (m_off >= 4) m_off -= 4;
        else if (m_size == 0) begin
          m_pad--;
          if (m_pad == 0) fin = 1;
        end else begin
          for (int i = m_off; i < 4 && m_size > 0; i++) begin
            m_size--;
            qb.push_back((m_pf ? 512 : 0) + ((m_size == 0 && m_a[12]) ? 256 : 0)
                         + int'((w >> (8 * i)) & 32'hFF));
            m_pf = 0;
          end
          m_off = 0;
          m_used++;
          if (m_size == 0 && m_pad == 0) fin = 1;
        end
      end
    endcase
    if (fin) begin
      m_state = 0;
      if (m_a[12]) begin
        m_used = 0;
        m_pf   = 0;
        push   = 1;
        ptag   = m_tag;
      end
      if (m_a[31]) exp_done = 1;
    end
  endtask

  always @(posedge clk) begin : model
    bit push_req;
    int push_tag_v;
    bit was_full;
    if (!rst_n) begin
      m_state = 0; m_a = '1; m_tag = 0; m_size = 0; m_off = 0; m_pad = 0;
      m_used = 0; m_pf = 0; exp_done = 0; exp_drop = 0;
      qb.delete(); qs.delete();
    end else begin
      exp_done = 0; exp_drop = 0; push_req = 0; push_tag_v = 0;
      if (soft_clear) begin
        m_state = 0; m_used = 0; m_pf = 0; m_a = '1;
        qb.delete();
      end else if (wr_valid && wr_ready) begin
        model_write(wr_data, push_req, push_tag_v);
      end
      if (stat_clear) qs.delete();
      else begin
        was_full = (qs.size() == SD);
        if (st_pop && qs.size() > 0) void'(qs.pop_front());
        if (push_req && !was_full) qs.push_back(push_tag_v);
      end
    end
  end

  // Cycle comparison away from the active edge
  always @(negedge clk) begin
    tx_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
    if (rst_n) begin
      chk("R12 wr_ready", int'(wr_ready), int'(qb.size() == 0));
      chk("R12 tx_valid", int'(tx_valid), int'(qb.size() != 0));
      if (tx_valid && qb.size() > 0) begin
        chk("R4 byte", int'(tx_data), qb[0] & 255);
        chk("R6 first marker", int'(tx_first), (qb[0] >> 9) & 1);
        chk("R6 last marker", int'(tx_last), (qb[0] >> 8) & 1);
        if (tx_ready) void'(qb.pop_front());
      end
      chk("R9 free words", int'(free_words), FW - m_used);
      chk("R8 full flag", int'(st_full), int'(qs.size() == SD));
      chk("R8 status valid", int'(st_valid), int'(qs.size() != 0));
      chk("R8 status tag", int'(st_tag), qs.size() != 0 ? qs[0] : 0);
      chk("R7 done pulse", int'(done_irq), int'(exp_done));
      chk("R9 drop pulse", int'(drop_evt), int'(exp_drop));
      if (done_irq) n_done++;
      if (drop_evt) n_drop++;
    end
  end

  function automatic logic [31:0] mk_a(input int size, input int off, input bit first,
                                       input bit last, input int sel, input bit ioc);
    logic [31:0] w;
    w = 32'h0460_C800;  // stray bits outside the kept fields
    w[10:0]  = size[10:0];
    w[20:16] = off[4:0];
    w[13]    = first;
    w[12]    = last;
    w[25:24] = sel[1:0];
    w[31]    = ioc;
    return w;
  endfunction

  task automatic wr(input logic [31:0] w);
    wr_valid = 1'b1;
    wr_data  = w;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_soft();
    soft_clear = 1'b1; @(negedge clk); soft_clear = 1'b0;
  endtask

  task automatic pulse_sclr();
    stat_clear = 1'b1; @(negedge clk); stat_clear = 1'b0;
  endtask

  task automatic pop_st();
    st_pop = 1'b1; @(negedge clk); st_pop = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 free after reset", int'(free_words), FW);
    chk("R1 no byte", int'(tx_valid), 0);
    chk("R1 status empty", int'(st_valid), 0);
    chk("R1 ready", int'(wr_ready), 1);

    // R2 R4 R6 R7: simple frame with interrupt
    wr(mk_a(6, 0, 1, 1, 0, 1));
    wr(32'hABCD_0000);
    wr(32'h4433_2211);
    wr(32'hFFFF_6655);
    idle(8);
    chk("R7 one interrupt", n_done, 1);
    chk("R2 tag captured", int'(st_tag), 16'hABCD);
    pop_st();

    // R3: leading offset 6 skips one word and two bytes
    wr(mk_a(5, 6, 1, 1, 0, 0));
    wr(32'h0101_0000);
    wr(32'hDEAD_BEEF);
    chk("R3 skipped word yields nothing", int'(tx_valid), 0);
    wr(32'h4433_2211);
    wr(32'h7766_5544);
    idle(8);
    chk("R3 frame completed", int'(st_valid), 1);
    pop_st();

    // R5: selector 1, 4 bytes -> 3 pad words
    stall_en = 1'b1;
    wr(mk_a(4, 0, 1, 1, 1, 0));
    wr(32'h0202_0000);
    wr(32'hA3A2_A1A0);
    wr(32'h0); wr(32'h0);
    idle(2);
    chk("R5 not done before last pad", int'(st_valid), 0);
    wr(32'h0);
    idle(2);
    chk("R5 done after third pad", int'(st_valid), 1);
    pop_st();
    // R5: selector 2, 4 bytes + offset 1 -> n=2, 6 pad words
    wr(mk_a(4, 1, 1, 1, 2, 0));
    wr(32'h0303_0000);
    wr(32'hB3B2_B1B0);
    wr(32'h0000_00B4);
    for (int i = 0; i < 5; i++) wr(32'h0);
    chk("R5 sel2 waits for six pads", int'(st_valid), 0);
    wr(32'h0);
    idle(2);
    chk("R5 sel2 done", int'(st_valid), 1);
    pop_st();
    // R5: selector 3 adds nothing
    wr(mk_a(3, 0, 1, 1, 3, 0));
    wr(32'h0404_0000);
    wr(32'h00C2_C1C0);
    idle(6);
    chk("R5 sel3 no pad", int'(st_valid), 1);
    pop_st();

    // R2 R6: two-segment frame, tag from the first segment only
    wr(mk_a(3, 0, 1, 0, 0, 0));
    wr(32'h1111_0000);
    wr(32'h00D2_D1D0);
    idle(6);
    chk("R6 no status before last segment", int'(st_valid), 0);
    wr(mk_a(2, 0, 0, 1, 0, 1));
    wr(32'hFFFF_0000);
    wr(32'h0000_E1E0);
    idle(8);
    chk("R2 tag from first segment", int'(st_tag), 16'h1111);
    chk("R9 used reset after last", int'(free_words), FW);
    pop_st();
    stall_en = 1'b0;

    // R10: soft clear mid-buffer
    wr(mk_a(8, 0, 1, 1, 0, 0));
    wr(32'h0505_0000);
    wr(32'h8765_4321);
    pulse_soft();
    chk("R10 used zeroed", int'(free_words), FW);
    chk("R10 pending bytes dropped", int'(tx_valid), 0);
    wr(mk_a(1, 0, 1, 1, 0, 0));
    wr(32'h0606_0000);
    wr(32'h0000_0077);
    idle(4);
    chk("R10 fresh frame after clear", int'(st_tag), 16'h0606);
    pop_st();

    // R8: fill the status FIFO past its depth
    for (int i = 0; i < SD + 8; i++) begin
      wr(mk_a(0, 0, 1, 1, 0, 0));
      wr({i[15:0], 16'h0000});
    end
    idle(2);
    chk("R8 full at depth", int'(st_full), 1);
    chk("R8 oldest kept", int'(st_tag), 0);
    for (int i = 0; i < SD; i++) pop_st();
    chk("R8 drained", int'(st_valid), 0);
    pop_st();
    chk("R8 empty pop ignored", int'(st_tag), 0);

    // R11: status clear
    for (int i = 0; i < 3; i++) begin
      wr(mk_a(0, 0, 1, 1, 0, 0));
      wr(32'h0900_0000);
    end
    idle(2);
    pulse_sclr();
    chk("R11 cleared", int'(st_valid), 0);

    // R9: fill the data storage and overflow it
    wr(mk_a(2044, 0, 1, 0, 0, 0));
    wr(32'h5555_0000);
    while (m_used < FW) begin
      if (m_state == 0) begin
        wr(mk_a(2044, 0, 0, 0, 0, 0));
        wr(32'h0);
      end else begin
        wr(32'h1357_9BDF);
      end
    end
    idle(6);
    chk("R9 no free words", int'(free_words), 0);
    wr(32'h2468_ACE0);
    idle(2);
    chk("R9 overflow pulse", n_drop, 1);
    chk("R9 count unchanged", int'(free_words), 0);
    pulse_soft();
    chk("R10 recovered", int'(free_words), FW);
    idle(4);
    summary();
  end

endmodule